// File: doc/BRIEF.md
# Software Flow-Control Character Generator

This block watches how full the receive FIFO is and tells the transmit shifter when to slip a software flow-control character into the outgoing stream. When the fill level climbs past a programmable halt threshold, it offers one pause character or a pause pair. When the level later drops to a programmable resume threshold, it offers one resume character or a resume pair. Between these two events the block keeps a paused state, so each crossing produces exactly one sequence.

Control characters use the same handshake as ordinary FIFO bytes. While a control byte is pending, the select line tells the shifter's input multiplexer to take this block's byte in place of the next queued data byte. Control characters therefore have priority over queued data, and the shifter still finishes the character it is currently sending. Each code is trimmed to the configured word length in the same way as a data byte.

Top module: `swfc_tx_gen`

## Requirements
- R1: After reset, `ctrl_sel` and `tx_valid` are low and the generator is in the not-paused state.
- R2: The halt level is `trig_cfg[3:0]` times 4. While the generator is not paused and the mode is not 00, a level strictly above the halt level at a clock edge starts a pause sequence, and `ctrl_sel` is high from that edge onwards. A level equal to the halt level starts nothing.
- R3: The resume level is `trig_cfg[7:4]` times 4. While the generator is paused and the mode is not 00, a level at or below the resume level starts a resume sequence. A level one above it starts nothing.
- R4: Only one pause sequence is sent per crossing, and no further pause is sent until a resume has been sent. A resume is sent only after a pause has been sent.
- R5: `tx_mode` selects what is sent. With 01 the block sends the set-A code (`pause_code_a` or `resume_code_a`). With 10 it sends the set-B code. With 11 it sends the set-A code and then the set-B code as two consecutive transfers.
- R6: With `tx_mode` = 00, no control character is generated at any FIFO level.
- R7: `word_len` trims each code: 00 keeps 5 bits, 01 keeps 6, 10 keeps 7 and 11 keeps all 8. Bits above the kept width read as zero.
- R8: A transfer happens on a clock edge where both `ctrl_sel` and `shifter_ready` are high, and `tx_valid` marks exactly those cycles. While `shifter_ready` is low, the pending byte stays offered: `ctrl_sel` stays high and `tx_byte` stays unchanged.
- R9: `rx_level` covers the full FIFO range from 0 to 64. A level of 64 counts as above any halt level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 7 | Receive FIFO fill count, 0 to 64 |
| trig_cfg | input | 8 | Low nibble sets the halt threshold, high nibble sets the resume threshold |
| tx_mode | input | 2 | Which code set(s) to send (00 off, 01 A, 10 B, 11 A then B) |
| word_len | input | 2 | Character width (00 five bits to 11 eight bits) |
| pause_code_a | input | 8 | First pause code |
| pause_code_b | input | 8 | Second pause code |
| resume_code_a | input | 8 | First resume code |
| resume_code_b | input | 8 | Second resume code |
| shifter_ready | input | 1 | Shifter is between characters and can take a byte |
| tx_byte | output | 8 | Trimmed control byte on offer |
| tx_valid | output | 1 | A control byte is transferred this cycle |
| ctrl_sel | output | 1 | Shifter must take `tx_byte` instead of FIFO data |

## Verification
A level change driven just after edge N is seen at edge N+1. `ctrl_sel` and the first code appear right after that edge, and with the shifter ready the transfer happens in that same cycle. The second code of a pair follows exactly one cycle later. The bench queues each expected byte before it moves the level. A monitor at every falling edge pops one entry from the queue for each `tx_valid` it sees, and it reports any strobe that arrives with the queue empty. After each step, the bench waits a few cycles, more than the longest sequence needs, and then checks that the queue is empty. The hold test samples `ctrl_sel` and `tx_byte` at the falling edges while the shifter is held not ready.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
   typedef enum logic [1:0] {SQ_IDLE, SQ_FIRST, SQ_SECOND} seq_state_t;
   typedef enum logic {K_PAUSE, K_RESUME} ctl_kind_t;
   localparam logic [1:0] MODE_OFF  = 2'b00;
   localparam logic [1:0] MODE_A    = 2'b01;
   localparam logic [1:0] MODE_B    = 2'b10;
   localparam logic [1:0] MODE_PAIR = 2'b11;
endpackage

// File: rtl/swfc_level_watch.sv
module swfc_level_watch #(
   parameter int CW    = 7,
   parameter int NIB   = 4,
   parameter int SHIFT = 2,
   parameter int DEPTH = 64
) (
   input  logic [CW-1:0]    level,
   input  logic [2*NIB-1:0] trig,
   output logic             above_halt,
   output logic             at_resume
);
   localparam int MAX_LVL = ((1 << NIB) - 1) << SHIFT;

   generate
      if (CW < NIB + SHIFT) begin : g_bad_cw
         $error("level width too narrow for scaled threshold");
      end
      if (MAX_LVL > DEPTH) begin : g_bad_scale
         $error("scaled threshold exceeds FIFO depth");
      end
   endgenerate

   logic [CW-1:0] halt_lvl;
   logic [CW-1:0] resume_lvl;

   assign halt_lvl   = CW'(trig[NIB-1:0]) << SHIFT;
   assign resume_lvl = CW'(trig[2*NIB-1:NIB]) << SHIFT;
   assign above_halt = level > halt_lvl;
   assign at_resume  = level <= resume_lvl;
endmodule

// File: rtl/swfc_char_fit.sv
module swfc_char_fit #(
   parameter int W     = 8,
   parameter bit SHORT = 1'b1
) (
   input  logic [W-1:0] code,
   input  logic [1:0]   wl,
   output logic [W-1:0] fitted
);
   generate
      if (W < 4) begin : g_bad_w
         $error("character width must allow four length settings");
      end
      if (SHORT) begin : g_trim
         logic [W-1:0] keep;
         assign keep   = {W{1'b1}} >> (2'd3 - wl);
         assign fitted = code & keep;
      end else begin : g_full
         assign fitted = code;
      end
   endgenerate
endmodule

// File: rtl/swfc_seq.sv
module swfc_seq
   import swfc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       above_halt,
   input  logic       at_resume,
   input  logic [1:0] mode,
   input  logic       ready,
   output logic       sel,
   output logic       use_b,
   output ctl_kind_t  kind
);
   seq_state_t state;
   logic       paused;
   logic       pair;
   logic       only_b;
   logic       want_pause;
   logic       want_resume;

   assign want_pause  = !paused && above_halt && (mode != MODE_OFF);
   assign want_resume = paused && at_resume && (mode != MODE_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         paused <= 1'b0;
         pair   <= 1'b0;
         only_b <= 1'b0;
         kind   <= K_PAUSE;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (want_pause || want_resume) begin
                  kind   <= want_pause ? K_PAUSE : K_RESUME;
                  paused <= want_pause;
                  pair   <= (mode == MODE_PAIR);
                  only_b <= (mode == MODE_B);
                  state  <= SQ_FIRST;
               end
            end
            SQ_FIRST: begin
               if (ready) state <= pair ? SQ_SECOND : SQ_IDLE;
            end
            SQ_SECOND: begin
               if (ready) state <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign sel   = (state != SQ_IDLE);
   assign use_b = (state == SQ_SECOND) || ((state == SQ_FIRST) && only_b);

   // R4
   pause_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && paused) |=> !(state == SQ_FIRST && kind == K_PAUSE));
   // R6
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && mode == MODE_OFF) |=> (state == SQ_IDLE));
   // R5
   pair_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_FIRST && pair && ready) |=> (state == SQ_SECOND));
endmodule

// File: rtl/swfc_tx_gen.sv
module swfc_tx_gen
   import swfc_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int W     = 8,
   parameter int NIB   = 4,
   parameter int SHIFT = 2,
   parameter bit SHORT = 1'b1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    rx_level,
   input  logic [2*NIB-1:0] trig_cfg,
   input  logic [1:0]       tx_mode,
   input  logic [1:0]       word_len,
   input  logic [W-1:0]     pause_code_a,
   input  logic [W-1:0]     pause_code_b,
   input  logic [W-1:0]     resume_code_a,
   input  logic [W-1:0]     resume_code_b,
   input  logic             shifter_ready,
   output logic [W-1:0]     tx_byte,
   output logic             tx_valid,
   output logic             ctrl_sel
);
   logic         above_halt;
   logic         at_resume;
   logic         use_b;
   ctl_kind_t    kind;
   logic [W-1:0] raw_code;

   swfc_level_watch #(.CW(CW), .NIB(NIB), .SHIFT(SHIFT), .DEPTH(DEPTH)) u_watch (
      .level      (rx_level),
      .trig       (trig_cfg),
      .above_halt (above_halt),
      .at_resume  (at_resume)
   );

   swfc_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .above_halt (above_halt),
      .at_resume  (at_resume),
      .mode       (tx_mode),
      .ready      (shifter_ready),
      .sel        (ctrl_sel),
      .use_b      (use_b),
      .kind       (kind)
   );

   always_comb begin
      if (kind == K_PAUSE) raw_code = use_b ? pause_code_b : pause_code_a;
      else                 raw_code = use_b ? resume_code_b : resume_code_a;
   end

   swfc_char_fit #(.W(W), .SHORT(SHORT)) u_fit (
      .code   (raw_code),
      .wl     (word_len),
      .fitted (tx_byte)
   );

   assign tx_valid = ctrl_sel && shifter_ready;

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_sel && !shifter_ready) |=> ctrl_sel);
   // R7
   trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_sel && word_len == 2'b00) |-> (tx_byte[W-1:W-3] == 3'b000));
endmodule

// File: tb/tb_swfc_tx_gen.sv
module tb_swfc_tx_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] rx_level = '0;
   logic [7:0] trig_cfg = 8'h4A;
   logic [1:0] tx_mode = 2'b01;
   logic [1:0] word_len = 2'b11;
   logic [7:0] pa = 8'hF3, pb = 8'hA5, ra = 8'hD1, rb = 8'h5A;
   logic       shifter_ready = 1'b1;
   logic [7:0] tx_byte;
   logic       tx_valid, ctrl_sel;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   swfc_tx_gen dut (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_cfg(trig_cfg),
      .tx_mode(tx_mode), .word_len(word_len),
      .pause_code_a(pa), .pause_code_b(pb), .resume_code_a(ra), .resume_code_b(rb),
      .shifter_ready(shifter_ready), .tx_byte(tx_byte), .tx_valid(tx_valid), .ctrl_sel(ctrl_sel)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 20000) begin
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && tx_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected byte: actual=%h expected=none", tx_byte);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (tx_byte !== e) begin
               bad++;
               $display("FAIL %s: actual=%h expected=%h", t, tx_byte, e);
            end
         end
      end
   end

   task automatic push(input logic [7:0] b, input string t);
      exp_q.push_back(b);
      tag_q.push_back(t);
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
      #1;
   endtask

   task automatic set_level(input logic [6:0] l);
      @(posedge clk); #1;
      rx_level = l;
      settle();
   endtask

   task automatic drained(input string t);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL %s: actual=%0d pending expected=0 pending", t, exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic chk(input logic act, input logic ex, input string t);
      total++;
      if (act !== ex) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", t, act, ex);
      end
   endtask

   initial begin
      rx_level = 7'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ctrl_sel, 1'b0, "R1 sel in reset");
      chk(tx_valid, 1'b0, "R1 valid in reset");
      @(posedge clk); #1;
      rst_n = 1'b1;
      settle();
      drained("R1 idle after reset");

      // halt = 40, resume = 16, mode A, 8 bits
      set_level(7'd40);
      @(negedge clk);
      chk(ctrl_sel, 1'b0, "R2 level equal halt");
      drained("R2 level equal halt");
      push(8'hF3, "R2 pause above halt");
      set_level(7'd41);
      drained("R2 pause above halt");
      set_level(7'd60);
      drained("R4 no second pause");
      set_level(7'd17);
      drained("R3 level above resume");
      push(8'hD1, "R3 resume at level");
      set_level(7'd16);
      drained("R3 resume at level");
      set_level(7'd10);
      drained("R4 no repeat resume");

      // pair mode
      tx_mode = 2'b11;
      push(8'hF3, "R5 pair pause first");
      push(8'hA5, "R5 pair pause second");
      set_level(7'd50);
      drained("R5 pair pause");
      push(8'hD1, "R5 pair resume first");
      push(8'h5A, "R5 pair resume second");
      set_level(7'd0);
      drained("R5 pair resume");

      // set B only, full level
      tx_mode = 2'b10;
      push(8'hA5, "R9 full level pause B");
      set_level(7'd64);
      drained("R9 full level");
      push(8'h5A, "R5 resume B only");
      set_level(7'd16);
      drained("R5 resume B only");

      // word lengths
      tx_mode = 2'b01;
      word_len = 2'b00;
      push(8'h13, "R7 five bit pause");
      set_level(7'd64);
      push(8'h11, "R7 five bit resume");
      set_level(7'd0);
      drained("R7 five bits");
      word_len = 2'b01;
      push(8'h33, "R7 six bit pause");
      set_level(7'd64);
      push(8'h11, "R7 six bit resume");
      set_level(7'd0);
      drained("R7 six bits");
      word_len = 2'b10;
      push(8'h73, "R7 seven bit pause");
      set_level(7'd64);
      push(8'h51, "R7 seven bit resume");
      set_level(7'd0);
      drained("R7 seven bits");
      word_len = 2'b11;

      // mode off
      tx_mode = 2'b00;
      set_level(7'd64);
      @(negedge clk);
      chk(ctrl_sel, 1'b0, "R6 off at full level");
      set_level(7'd0);
      drained("R6 off no bytes");

      // hold while shifter busy
      tx_mode = 2'b01;
      @(posedge clk); #1;
      shifter_ready = 1'b0;
      rx_level = 7'd64;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(ctrl_sel, 1'b1, "R8 sel held busy");
      chk(tx_valid, 1'b0, "R8 no strobe busy");
      chk(tx_byte == 8'hF3, 1'b1, "R8 byte offered busy");
      repeat (3) @(negedge clk);
      chk(ctrl_sel, 1'b1, "R8 sel still held");
      chk(tx_byte == 8'hF3, 1'b1, "R8 byte stable");
      push(8'hF3, "R8 released byte");
      @(posedge clk); #1;
      shifter_ready = 1'b1;
      settle();
      @(negedge clk);
      chk(ctrl_sel, 1'b0, "R8 sel drops after transfer");
      drained("R8 released");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule